// File: doc/BRIEF.md
# Sticky Error Status Bank with Parity Readout

This block holds a chip's error flags until software has seen them. Events from the core arrive as one-cycle pulses, one line per flag. Each pulse sets a sticky flag, and the flag stays set until the serial host reads the register that holds it. The flags are grouped into a fixed number of read-only registers. Each register returns its flag bits with an even-parity bit added on top, so the host can spot a corrupted read and read again.

A registered, active-low error line tells the host that at least one flag is set. The flags and the error line only move while the serial chip select is inactive (high), so what the host reads stays steady for the whole transfer. Events that arrive during a transfer are held aside and merged in once chip select goes high. A read that finishes during a transfer marks its register for clearing, and that clear is applied at the same moment. A new event always wins over a clear in the same cycle. The serial shifter sits outside this block. It supplies the register address and a strobe when a read has completed.

Top module: `stat_guard`

## Requirements
- R1: After reset every flag is zero, `rd_data_o` reads 0 at every address and `err_n_o` is 1.
- R2: While `cs_n_i` is 1, a pulse on event bit k*FLAG_W+j sets bit j of register k at that clock edge. The flag then stays set until that register is cleared.
- R3: `rd_data_o[FLAG_W-1:0]` shows the flags of the register selected by `rd_addr_i`. `rd_data_o[FLAG_W]` is the XOR of those flag bits, so the full word always has an even number of ones.
- R4: `err_n_o` is 0 exactly when at least one flag in any register is set, and 1 otherwise. It follows the flags at the same clock edge.
- R5: While `cs_n_i` is 0, no flag and no change on `err_n_o` takes place at a clock edge.
- R6: Events that pulse while `cs_n_i` is 0 are not lost. They set their flags at the first edge at which `cs_n_i` is 1.
- R7: A `rd_done_i` pulse while `cs_n_i` is 1 clears all flags of register `rd_addr_i` at that edge. The other registers are unchanged.
- R8: A `rd_done_i` pulse while `cs_n_i` is 0 is remembered. The addressed register is cleared at the first edge at which `cs_n_i` is 1.
- R9: An event applied at the same edge as a clear of its register leaves its flag set. This holds whether the event and the clear are immediate or were held pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, synchronous to clk, active low |
| evt_i | input | NUM_REGS*FLAG_W | One-cycle error event pulses; bit k*FLAG_W+j feeds bit j of register k |
| rd_done_i | input | 1 | Strobe: a read of register rd_addr_i has completed |
| rd_addr_i | input | ADDR_W | Register index for read data and for clearing |
| rd_data_o | output | FLAG_W+1 | Parity bit above the flag bits of the selected register |
| err_n_o | output | 1 | Active-low error indication, registered |

## Verification
The bench builds the block with its default parameters: four registers of seven flags and a two-bit address. With these settings every address code is a real register, and the parity bit covers an odd-width field. An all-ones flag pattern therefore reads back with the parity bit set. Random chip-select runs of varied length are mixed with sparse events and reads. This brings in reads that complete during a transfer, events that arrive during a transfer, and events that land on the same edge as a deferred clear.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;

    parameter int unsigned DEF_REGS  = 4;
    parameter int unsigned DEF_FLAGS = 7;

    // state of the serial link as seen from the system clock
    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_BUSY = 1'b1
    } link_e;

    function automatic link_e link_of(input logic cs_n);
        return cs_n ? LINK_IDLE : LINK_BUSY;
    endfunction

endpackage

// File: rtl/stat_pending.sv
module stat_pending
    import stat_guard_pkg::*;
#(
    parameter int unsigned NUM_REGS = DEF_REGS,
    parameter int unsigned FLAG_W   = DEF_FLAGS,
    parameter int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  link_e                        link,
    input  logic [NUM_REGS*FLAG_W-1:0]   evt_i,
    input  logic                         rd_done_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [NUM_REGS*FLAG_W-1:0]   set_o,
    output logic [NUM_REGS*FLAG_W-1:0]   clr_o
);

    localparam int unsigned TOT_W = NUM_REGS * FLAG_W;

    typedef struct packed {
        logic [TOT_W-1:0] evt;
        logic [TOT_W-1:0] clr;
    } pend_t;

    pend_t st_d, st_q;

    logic [TOT_W-1:0] rd_mask;

    // expand the read strobe into a per-flag clear mask
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
        assign rd_mask[k*FLAG_W +: FLAG_W] =
            {FLAG_W{rd_done_i && (rd_addr_i == ADDR_W'(k))}};
    end

    always_comb begin
        st_d  = st_q;
        set_o = '0;
        clr_o = '0;
        if (link == LINK_IDLE) begin
            set_o  = evt_i | st_q.evt;
            clr_o  = rd_mask | st_q.clr;
            st_d   = '0;
        end else begin
            st_d.evt = st_q.evt | evt_i;
            st_d.clr = st_q.clr | rd_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    pend_clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link == LINK_BUSY) |=> ((st_q.clr & $past(st_q.clr)) == $past(st_q.clr)));

    // R6
    pend_evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link == LINK_BUSY) |=> ((st_q.evt & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_guard_pkg::*;
#(
    parameter int unsigned NUM_REGS = DEF_REGS,
    parameter int unsigned FLAG_W   = DEF_FLAGS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  link_e                        link,
    input  logic [NUM_REGS*FLAG_W-1:0]   set_i,
    input  logic [NUM_REGS*FLAG_W-1:0]   clr_i,
    output logic [NUM_REGS*FLAG_W-1:0]   flags_o,
    output logic                         err_n_o
);

    localparam int unsigned TOT_W = NUM_REGS * FLAG_W;

    typedef struct packed {
        logic [TOT_W-1:0] flags;
        logic             err_n;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (link == LINK_IDLE) begin
            // a set beats a clear on the same bit
            st_d.flags = (st_q.flags & ~clr_i) | set_i;
            st_d.err_n = ~|st_d.flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.err_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign err_n_o = st_q.err_n;

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link == LINK_BUSY) |=> ($stable(st_q.flags) && $stable(st_q.err_n)));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link == LINK_IDLE) |=> ((st_q.flags & $past(set_i)) == $past(set_i)));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

endmodule

// File: rtl/stat_readout.sv
module stat_readout
    import stat_guard_pkg::*;
#(
    parameter int unsigned NUM_REGS = DEF_REGS,
    parameter int unsigned FLAG_W   = DEF_FLAGS,
    parameter int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [NUM_REGS*FLAG_W-1:0]   flags_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [FLAG_W:0]              rd_data_o
);

    logic [NUM_REGS-1:0][FLAG_W:0] word;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
        assign word[k] = {^flags_i[k*FLAG_W +: FLAG_W], flags_i[k*FLAG_W +: FLAG_W]};
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr_i == ADDR_W'(k)) rd_data_o = word[k];
        end
    end

endmodule

// File: rtl/stat_guard.sv
module stat_guard
    import stat_guard_pkg::*;
#(
    parameter int unsigned NUM_REGS = DEF_REGS,
    parameter int unsigned FLAG_W   = DEF_FLAGS,
    parameter int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n_i,
    input  logic [NUM_REGS*FLAG_W-1:0]   evt_i,
    input  logic                         rd_done_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [FLAG_W:0]              rd_data_o,
    output logic                         err_n_o
);

    localparam int unsigned TOT_W = NUM_REGS * FLAG_W;

    link_e            link;
    logic [TOT_W-1:0] set_mask;
    logic [TOT_W-1:0] clr_mask;
    logic [TOT_W-1:0] flags;

    assign link = link_of(cs_n_i);

    stat_pending #(.NUM_REGS(NUM_REGS), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .link      (link),
        .evt_i     (evt_i),
        .rd_done_i (rd_done_i),
        .rd_addr_i (rd_addr_i),
        .set_o     (set_mask),
        .clr_o     (clr_mask)
    );

    stat_bank #(.NUM_REGS(NUM_REGS), .FLAG_W(FLAG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .link    (link),
        .set_i   (set_mask),
        .clr_i   (clr_mask),
        .flags_o (flags),
        .err_n_o (err_n_o)
    );

    stat_readout #(.NUM_REGS(NUM_REGS), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) u_rd (
        .flags_i   (flags),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    // R4
    err_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_n_o == (flags == '0));

    // R3
    even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^rd_data_o) == 1'b0);

endmodule

// File: tb/stat_guard_test.sv
`timescale 1ns/1ps
module stat_guard_test;

    localparam int NR = 4;
    localparam int FW = 7;
    localparam int TW = NR * FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic [TW-1:0] evt = '0;
    logic          rd_done = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [FW:0]   rd_data;
    logic          err_n;

    int vectors = 0;
    int miscompares = 0;

    logic [FW-1:0] m_flags [NR];
    logic [FW-1:0] m_pevt  [NR];
    logic [FW-1:0] m_pclr  [NR];

    always #2.5 clk = ~clk;

    stat_guard uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n),
        .evt_i     (evt),
        .rd_done_i (rd_done),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .err_n_o   (err_n)
    );

    function automatic logic par_of(input logic [FW-1:0] f);
        int n = 0;
        for (int i = 0; i < FW; i++) if (f[i]) n++;
        return (n % 2) == 1;
    endfunction

    function automatic logic [FW:0] exp_word(input int a);
        return {par_of(m_flags[a]), m_flags[a]};
    endfunction

    function automatic logic exp_err_n();
        for (int k = 0; k < NR; k++) if (m_flags[k] != '0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_edge(input logic cs, input logic [TW-1:0] ev,
                              input logic rd, input logic [1:0] a);
        for (int k = 0; k < NR; k++) begin
            logic [FW-1:0] rdm;
            rdm = (rd && a == 2'(k)) ? {FW{1'b1}} : '0;
            if (cs) begin
                m_flags[k] = (m_flags[k] & ~(m_pclr[k] | rdm)) | ev[k*FW +: FW] | m_pevt[k];
                m_pevt[k]  = '0;
                m_pclr[k]  = '0;
            end else begin
                m_pevt[k] = m_pevt[k] | ev[k*FW +: FW];
                m_pclr[k] = m_pclr[k] | rdm;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [FW:0] ew;
        logic        ee;
        ew = exp_word(int'(rd_addr));
        ee = exp_err_n();
        vectors++;
        if (rd_data !== ew) begin
            miscompares++;
            $display("FAIL %s rd_data addr=%0d actual=%h expected=%h", tag, rd_addr, rd_data, ew);
        end
        vectors++;
        if (err_n !== ee) begin
            miscompares++;
            $display("FAIL %s err_n actual=%b expected=%b", tag, err_n, ee);
        end
    endtask

    task automatic step(input logic cs, input logic [TW-1:0] ev, input logic rd,
                        input logic [1:0] a, input string tag);
        cs_n = cs; evt = ev; rd_done = rd; rd_addr = a;
        @(posedge clk);
        model_edge(cs, ev, rd, a);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic peek_all(input string tag);
        for (int k = 0; k < NR; k++) step(1'b1, '0, 1'b0, 2'(k), tag);
    endtask

    function automatic logic [TW-1:0] bit_at(input int r, input int b);
        logic [TW-1:0] v = '0;
        v[r*FW + b] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [TW-1:0] ev;
        logic cs;
        int run;
        void'($urandom(32'h5A17_C0DE));
        for (int k = 0; k < NR; k++) begin
            m_flags[k] = '0; m_pevt[k] = '0; m_pclr[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at every address
        for (int k = 0; k < NR; k++) begin
            rd_addr = 2'(k);
            #0.1 compare("R1");
        end

        // R2 single event sets flag, stays set
        step(1'b1, bit_at(1, 3), 1'b0, 2'd1, "R2");
        step(1'b1, '0, 1'b0, 2'd1, "R2");
        step(1'b1, '0, 1'b0, 2'd1, "R4");

        // R3 all-ones pattern (odd count -> parity 1) and 2-bit pattern
        step(1'b1, {{(TW-FW){1'b0}}, {FW{1'b1}}}, 1'b0, 2'd0, "R3");
        step(1'b1, bit_at(2, 0) | bit_at(2, 6), 1'b0, 2'd2, "R3");

        // R7 clear register 0 only
        step(1'b1, '0, 1'b1, 2'd0, "R7");
        peek_all("R7");

        // R5 freeze: events while busy do nothing yet
        step(1'b0, bit_at(3, 5), 1'b0, 2'd3, "R5");
        step(1'b0, bit_at(0, 1), 1'b0, 2'd0, "R5");
        // R8 read during transfer: deferred clear of register 2
        step(1'b0, '0, 1'b1, 2'd2, "R8");
        step(1'b0, '0, 1'b0, 2'd2, "R8");
        // R6 release: pending events merge, pending clear applies
        step(1'b1, '0, 1'b0, 2'd3, "R6");
        peek_all("R6");

        // R9 event on same edge as immediate clear
        step(1'b1, bit_at(1, 0), 1'b1, 2'd1, "R9");
        // R9 pending event with pending clear
        step(1'b0, bit_at(3, 2), 1'b0, 2'd3, "R9");
        step(1'b0, '0, 1'b1, 2'd3, "R9");
        step(1'b1, '0, 1'b0, 2'd3, "R9");
        peek_all("R9");

        // clear everything, expect error line released
        for (int k = 0; k < NR; k++) step(1'b1, '0, 1'b1, 2'(k), "R4");
        peek_all("R4");

        // random phase
        cs = 1'b1; run = 0;
        for (int i = 0; i < 4000; i++) begin
            if (run == 0) begin
                cs  = ($urandom % 3) != 0;
                run = 1 + ($urandom % 12);
            end
            run--;
            ev = '0;
            if (($urandom % 5) == 0) ev = bit_at($urandom % NR, $urandom % FW);
            if (($urandom % 23) == 0) ev = ev | TW'($urandom);
            step(cs, ev, ($urandom % 6) == 0, 2'($urandom % NR), cs ? "R7" : "R5");
        end
        peek_all("R6");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule